// File: doc/BRIEF.md
# Serial Character Transmitter with Line Break

This block is the sending half of a USART. A host places one character at a time into a single-entry holding register. When the line is free, the character moves into a shift register. That shift register sends it bit by bit on `txd`, one step per bit period. The bit period is counted in pulses of `tx_tick`, the transmit clock enable. Because the holding register frees up as soon as its byte reaches the shifter, the host can queue the next byte while the current one is still going out. Characters then follow one another with only a single-cycle mark between frames.

In asynchronous framing, each character is sent as:
- a low start bit;
- 5 to 8 data bits, least significant first;
- an optional even or odd parity bit;
- one or two high stop bits.

Each bit lasts 1, 16 or 64 ticks. In synchronous framing, there are no start or stop bits and each bit lasts one tick. When no host data is waiting at a character boundary, the shifter sends a sync character. With two sync characters selected, it alternates between them.

No new character is started unless `cmd_txen` is high and `cts_n` is low. A character already in flight always finishes. `cmd_break` forces the line low for as long as it is held.

The sequencer uses five named states:
- **IDLE**: line marks.
- **START**: start bit.
- **DATA**: data bits.
- **PAR**: parity bit.
- **STOP**: stop bits.

Transitions:
- IDLE→START (asynchronous load) or IDLE→DATA (synchronous load). A load happens when enabled and either host data is waiting or synchronous mode is on.
- START→DATA at the end of the start bit.
- DATA→PAR after the last data bit when parity is on.
- DATA or PAR→STOP after the last frame bit in asynchronous mode.
- STOP→IDLE after the final stop bit.
- DATA or PAR→DATA directly, with the next character loaded, in synchronous mode while enabled.
- DATA or PAR→IDLE in synchronous mode when the enable has dropped.

Top module: `sertx_core`

## Requirements
- R1: After reset, `txd`=1, `txrdy_stat`=1, `txempty`=1, and `txrdy_pin`=0 while `cmd_txen` is low.
- R2: A write (`wr_en`=1) while `txrdy_stat`=1 stores `wr_data` and drops `txrdy_stat` on the next cycle. A write while `txrdy_stat`=0 is ignored and its byte is never sent.
- R3: A character is started only while `cmd_txen`=1 and `cts_n`=0. Otherwise the waiting byte stays held and the line keeps its idle level.
- R4: An asynchronous frame has these fields, in order:
  - a 0 start bit;
  - N data bits, LSB first, where `cfg_len` 00/01/10/11 selects N=5/6/7/8;
  - a parity bit if `cfg_par_en`=1;
  - one 1 stop bit, or two if `cfg_two_stop`=1.
- R5: The parity bit is computed over the N data bits only. With `cfg_par_odd`=0 the number of ones in data plus parity is even; with `cfg_par_odd`=1 it is odd.
- R6: In asynchronous mode each bit lasts F `tx_tick` pulses. `cfg_baud`=00 selects F=1, 01 selects F=16, and 10 or 11 selects F=64.
- R7: `txrdy_stat` rises once the held byte has moved into the shifter, while that byte is still being sent. A byte written then is sent as the next frame.
- R8: `txrdy_pin` = `txrdy_stat` AND `cmd_txen` AND NOT `cts_n`.
- R9: `txempty` is high only when no host byte is held or being shifted. It falls after an accepted write and rises again after the last stop bit.
- R10: While `cmd_break`=1, `txd`=0 on every cycle.
- R11: Synchronous mode (`cfg_sync`=1) behaves as follows:
  - each character is N data bits (plus parity if enabled) with no start or stop bits, one tick per bit;
  - a waiting host byte is sent first;
  - at a boundary with no byte held, `sync_a` is sent, or `sync_a`/`sync_b` alternately, starting with `sync_a`, when `cfg_two_sync`=1;
  - `txempty` stays high while sync characters are sent.
- R12: With no character in flight, break off and asynchronous mode, `txd` rests at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tx_tick | input | 1 | Transmit clock enable, one pulse per transmit clock period |
| cfg_sync | input | 1 | 1 = synchronous framing |
| cfg_baud | input | 2 | Bit length in ticks: 00=1, 01=16, 1x=64 |
| cfg_len | input | 2 | Data bits: 00=5 … 11=8 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_two_stop | input | 1 | Two stop bits |
| cfg_two_sync | input | 1 | Alternate two sync characters |
| sync_a | input | 8 | First sync character |
| sync_b | input | 8 | Second sync character |
| cmd_txen | input | 1 | Transmit enable command |
| cmd_break | input | 1 | Force line to spacing |
| cts_n | input | 1 | Clear to send, active low |
| wr_en | input | 1 | Holding register write strobe |
| wr_data | input | 8 | Byte to write |
| txd | output | 1 | Serial line |
| txrdy_stat | output | 1 | Holding register free (status) |
| txrdy_pin | output | 1 | Holding register free, gated by enable and CTS |
| txempty | output | 1 | No host data held or in flight |

## Verification
The checker watches several rules on every clock:
- break forces spacing;
- the ready pin never shows ready when the status does not;
- an accepted write always clears ready;
- empty implies ready;
- a CTS-blocked idle asynchronous line stays marking.

Frame layout, bit order, parity, bit length per baud factor, ignored writes, back-to-back queuing and the order of sync characters only show up across whole characters. The bench checks these by decoding the line at tick resolution in its scenarios.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int CHAR_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } txst_e;

    typedef struct packed {
        logic       sync_mode;
        logic [1:0] baud;
        logic [1:0] len;
        logic       par_en;
        logic       par_odd;
        logic       two_stop;
        logic       two_sync;
    } txcfg_t;

    // number of data bits selected by the length field
    function automatic logic [3:0] char_bits(input logic [1:0] len);
        return 4'd5 + {2'b00, len};
    endfunction

    function automatic logic calc_par(input logic [CHAR_W-1:0] d,
                                      input logic [1:0] len,
                                      input logic odd);
        logic p;
        p = odd;
        for (int i = 0; i < CHAR_W; i++) begin
            if (i < int'(char_bits(len))) p ^= d[i];
        end
        return p;
    endfunction

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         take,
    output logic         full,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= 1'b0;
            q    <= '0;
        end else if (take) begin
            full <= 1'b0;
        end else if (wr_en && !full) begin
            full <= 1'b1;
            q    <= wr_data;
        end
    end

endmodule

// File: rtl/sertx_bittimer.sv
module sertx_bittimer #(
    parameter int FAST_DIV = 16,
    parameter int SLOW_DIV = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       restart,
    input  logic       sync_mode,
    input  logic [1:0] baud,
    output logic       bit_end
);

    localparam int CNT_W = $clog2(SLOW_DIV);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    always_comb begin
        if (sync_mode || baud == 2'b00) last = '0;
        else if (baud == 2'b01)         last = CNT_W'(FAST_DIV - 1);
        else                            last = CNT_W'(SLOW_DIV - 1);
    end

    assign bit_end = tick && (cnt == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt <= '0;
        else if (restart)      cnt <= '0;
        else if (tick)         cnt <= (cnt == last) ? '0 : cnt + 1'b1;
    end

endmodule

// File: rtl/sertx_seq.sv
module sertx_seq
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  txcfg_t            cfg,
    input  logic              hold_full,
    input  logic [CHAR_W-1:0] hold_q,
    input  logic [CHAR_W-1:0] sync_a,
    input  logic [CHAR_W-1:0] sync_b,
    input  logic              bit_end,
    output logic              take,
    output logic              restart,
    output logic              line_bit,
    output logic              host_busy
);

    txst_e             st, st_nx;
    logic [CHAR_W-1:0] sh;
    logic [2:0]        idx;
    logic              pbit;
    logic              stop2;
    logic              sel_b;
    logic              carry_host;
    logic [3:0]        nbits;
    logic              last_data;
    logic              char_done;
    logic              load;
    logic [CHAR_W-1:0] src;

    assign nbits     = char_bits(cfg.len);
    assign last_data = ({1'b0, idx} == (nbits - 4'd1));

    // end of the final bit of the current character
    always_comb begin
        char_done = 1'b0;
        unique case (st)
            ST_DATA:  char_done = bit_end && last_data && !cfg.par_en && cfg.sync_mode;
            ST_PAR:   char_done = bit_end && cfg.sync_mode;
            ST_STOP:  char_done = bit_end && (!cfg.two_stop || stop2);
            default:  char_done = 1'b0;
        endcase
    end

    assign load = ((st == ST_IDLE) && go && (hold_full || cfg.sync_mode)) ||
                  (char_done && cfg.sync_mode && go);
    assign take    = load && hold_full;
    assign restart = load;
    assign src     = hold_full ? hold_q :
                     ((cfg.two_sync && sel_b) ? sync_b : sync_a);

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: begin
                if (load) st_nx = cfg.sync_mode ? ST_DATA : ST_START;
            end
            ST_START: begin
                if (bit_end) st_nx = ST_DATA;
            end
            ST_DATA: begin
                if (bit_end && last_data) begin
                    if (cfg.par_en)         st_nx = ST_PAR;
                    else if (cfg.sync_mode) st_nx = load ? ST_DATA : ST_IDLE;
                    else                    st_nx = ST_STOP;
                end
            end
            ST_PAR: begin
                if (bit_end) begin
                    if (cfg.sync_mode) st_nx = load ? ST_DATA : ST_IDLE;
                    else               st_nx = ST_STOP;
                end
            end
            ST_STOP: begin
                if (char_done) st_nx = ST_IDLE;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh         <= '0;
            idx        <= '0;
            pbit       <= 1'b0;
            stop2      <= 1'b0;
            sel_b      <= 1'b0;
            carry_host <= 1'b0;
        end else if (load) begin
            sh         <= src;
            idx        <= '0;
            pbit       <= calc_par(src, cfg.len, cfg.par_odd);
            stop2      <= 1'b0;
            carry_host <= hold_full;
            if (!hold_full) sel_b <= cfg.two_sync & ~sel_b;
        end else begin
            if (bit_end && st == ST_DATA) begin
                sh  <= sh >> 1;
                idx <= idx + 3'd1;
            end
            if (bit_end && st == ST_STOP) stop2 <= 1'b1;
            if (char_done) carry_host <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        line_bit = 1'b1;
        unique case (st)
            ST_IDLE:  line_bit = 1'b1;
            ST_START: line_bit = 1'b0;
            ST_DATA:  line_bit = sh[0];
            ST_PAR:   line_bit = pbit;
            ST_STOP:  line_bit = 1'b1;
            default:  line_bit = 1'b1;
        endcase
    end

    assign host_busy = carry_host;

endmodule

// File: rtl/sertx_core.sv
module sertx_core
    import sertx_pkg::*;
#(
    parameter int FAST_DIV = 16,
    parameter int SLOW_DIV = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_tick,
    input  logic              cfg_sync,
    input  logic [1:0]        cfg_baud,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_two_stop,
    input  logic              cfg_two_sync,
    input  logic [CHAR_W-1:0] sync_a,
    input  logic [CHAR_W-1:0] sync_b,
    input  logic              cmd_txen,
    input  logic              cmd_break,
    input  logic              cts_n,
    input  logic              wr_en,
    input  logic [CHAR_W-1:0] wr_data,
    output logic              txd,
    output logic              txrdy_stat,
    output logic              txrdy_pin,
    output logic              txempty
);

    txcfg_t            cfg;
    logic              go;
    logic              hold_full;
    logic [CHAR_W-1:0] hold_q;
    logic              take;
    logic              restart;
    logic              bit_end;
    logic              line_bit;
    logic              host_busy;

    assign cfg = '{sync_mode: cfg_sync, baud: cfg_baud, len: cfg_len,
                   par_en: cfg_par_en, par_odd: cfg_par_odd,
                   two_stop: cfg_two_stop, two_sync: cfg_two_sync};
    assign go  = cmd_txen && !cts_n;

    sertx_hold #(.W(CHAR_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (take),
        .full    (hold_full),
        .q       (hold_q)
    );

    sertx_bittimer #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tx_tick),
        .restart   (restart),
        .sync_mode (cfg_sync),
        .baud      (cfg_baud),
        .bit_end   (bit_end)
    );

    sertx_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .cfg       (cfg),
        .hold_full (hold_full),
        .hold_q    (hold_q),
        .sync_a    (sync_a),
        .sync_b    (sync_b),
        .bit_end   (bit_end),
        .take      (take),
        .restart   (restart),
        .line_bit  (line_bit),
        .host_busy (host_busy)
    );

    assign txd        = cmd_break ? 1'b0 : line_bit;
    assign txrdy_stat = !hold_full;
    assign txrdy_pin  = !hold_full && go;
    assign txempty    = !hold_full && !host_busy;

endmodule

// File: rtl/sertx_core_chk.sv
module sertx_core_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_break,
    input logic cts_n,
    input logic cfg_sync,
    input logic wr_en,
    input logic txd,
    input logic txrdy_stat,
    input logic txrdy_pin,
    input logic txempty
);

    // R10
    break_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_break |-> !txd);

    // R8
    pin_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txrdy_pin |-> txrdy_stat);

    // R2
    accept_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && txrdy_stat) |=> !txrdy_stat);

    // R9
    empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txempty |-> txrdy_stat);

    // R3
    blocked_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_sync && txempty && cts_n && !cmd_break) |=> (txd || cmd_break));

endmodule

bind sertx_core sertx_core_chk u_chk (.*);

// File: tb/sim_sertx_core.sv
module sim_sertx_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_tick = 1'b0;
    logic       cfg_sync = 1'b0;
    logic [1:0] cfg_baud = 2'b00;
    logic [1:0] cfg_len = 2'b11;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_two_stop = 1'b0;
    logic       cfg_two_sync = 1'b0;
    logic [7:0] sync_a = 8'h00;
    logic [7:0] sync_b = 8'h00;
    logic       cmd_txen = 1'b0;
    logic       cmd_break = 1'b0;
    logic       cts_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       txd, txrdy_stat, txrdy_pin, txempty;

    int checks = 0;
    int errors = 0;
    bit sq[$];

    always #2 clk = ~clk;

    sertx_core u0 (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input bit tk);
        @(negedge clk);
        tx_tick = tk;
        wr_en   = 1'b0;
        #1;
        if (tk) sq.push_back(txd);
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        tx_tick = 1'b0;
        wr_en   = 1'b1;
        wr_data = d;
        #1;
    endtask

    task automatic run_ticks(input int n);
        int got;
        got = 0;
        while (got < n) begin
            bit tk;
            tk = ($urandom % 2) == 1;
            cyc(tk);
            if (tk) got++;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cmd_txen = 1'b0; cmd_break = 1'b0; cts_n = 1'b0;
        cfg_sync = 1'b0; tx_tick = 1'b0; wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    function automatic int fdiv(input logic [1:0] b);
        return (b == 2'b00) ? 1 : (b == 2'b01) ? 16 : 64;
    endfunction

    // expected asynchronous frame, bit 0 sent first
    function automatic int mk_frame(input logic [7:0] d, input int n, input bit pe,
                                    input bit po, input bit ts, output logic [11:0] e);
        int k;
        bit p;
        e = '1;
        e[0] = 1'b0;
        k = 1;
        p = po;
        for (int i = 0; i < n; i++) begin
            e[k] = d[i];
            p ^= d[i];
            k++;
        end
        if (pe) begin
            e[k] = p;
            k++;
        end
        e[k] = 1'b1;
        k++;
        if (ts) begin
            e[k] = 1'b1;
            k++;
        end
        return k;
    endfunction

    task automatic check_frame(input int f, input logic [11:0] e, input int nb,
                               input string req, inout int pos);
        int p;
        int bad;
        p = pos;
        bad = 0;
        while (p < sq.size() && sq[p] == 1'b1) p++;
        for (int b = 0; b < nb; b++) begin
            for (int j = 0; j < f; j++) begin
                if (p >= sq.size() || sq[p] != e[b]) bad++;
                p++;
            end
        end
        pos = p;
        chk(bad == 0, req, "frame samples wrong", bad, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [11:0] e;
        int nb, pos, ones;
        void'($urandom(32'd4321));

        // R1 reset state
        do_reset();
        chk(txd == 1'b1, "R1", "txd", txd, 1);
        chk(txrdy_stat == 1'b1, "R1", "txrdy_stat", txrdy_stat, 1);
        chk(txempty == 1'b1, "R1", "txempty", txempty, 1);
        chk(txrdy_pin == 1'b0, "R1", "txrdy_pin", txrdy_pin, 0);

        // R8 pin gating
        cmd_txen = 1'b1; cts_n = 1'b0; #1;
        chk(txrdy_pin == 1'b1, "R8", "pin enabled", txrdy_pin, 1);
        cts_n = 1'b1; #1;
        chk(txrdy_pin == 1'b0 && txrdy_stat == 1'b1, "R8", "pin cts gated", txrdy_pin, 0);

        // R3 R2 R12 blocked by CTS, second write ignored
        cfg_baud = 2'b00; cfg_len = 2'b11; cfg_par_en = 1'b0; cfg_two_stop = 1'b0;
        sq.delete();
        wr(8'h55);
        cyc(1'b0);
        chk(txrdy_stat == 1'b0, "R2", "stat after write", txrdy_stat, 0);
        chk(txempty == 1'b0, "R9", "empty after write", txempty, 0);
        wr(8'hAA);
        run_ticks(50);
        ones = 0;
        foreach (sq[i]) ones += sq[i];
        chk(ones == 50, "R3", "line while blocked (ones)", ones, 50);
        sq.delete();
        cts_n = 1'b0;
        run_ticks(60);
        nb = mk_frame(8'h55, 8, 0, 0, 0, e);
        pos = 0;
        check_frame(1, e, nb, "R2", pos);
        ones = 0;
        for (int i = pos; i < sq.size(); i++) ones += sq[i];
        chk(ones == sq.size() - pos, "R2", "ignored byte not sent", ones, sq.size() - pos);

        // R4 R5 R6 R9 random asynchronous frames
        for (int i = 0; i < 10; i++) begin
            logic [7:0] d;
            int n, f;
            bit pe, po, ts;
            logic [1:0] b;
            d = 8'($urandom);
            n = 5 + int'($urandom % 4);
            pe = 1'($urandom); po = 1'($urandom); ts = 1'($urandom);
            b = 2'($urandom % 3);
            if (i == 0) b = 2'b11;
            f = fdiv(b);
            cfg_len = 2'(n - 5); cfg_par_en = pe; cfg_par_odd = po;
            cfg_two_stop = ts; cfg_baud = b;
            sq.delete();
            wr(d);
            nb = mk_frame(d, n, pe, po, ts, e);
            run_ticks(nb * f + 6);
            pos = 0;
            check_frame(f, e, nb, pe ? "R5" : "R4", pos);
            chk(txempty == 1'b1, "R9", "empty after stop", txempty, 1);
            chk(txrdy_stat == 1'b1, "R6", "ready after frame", txrdy_stat, 1);
        end

        // R7 back-to-back frames, 16x
        cfg_baud = 2'b01; cfg_len = 2'b11; cfg_par_en = 1'b0; cfg_two_stop = 1'b0;
        sq.delete();
        wr(8'h81);
        cyc(1'b0); cyc(1'b0); cyc(1'b0);
        chk(txrdy_stat == 1'b1, "R7", "ready while shifting", txrdy_stat, 1);
        chk(txempty == 1'b0, "R9", "not empty while shifting", txempty, 0);
        wr(8'h3E);
        cyc(1'b0);
        chk(txrdy_stat == 1'b0, "R7", "second byte held", txrdy_stat, 0);
        run_ticks(2 * 10 * 16 + 20);
        pos = 0;
        nb = mk_frame(8'h81, 8, 0, 0, 0, e);
        check_frame(16, e, nb, "R7", pos);
        nb = mk_frame(8'h3E, 8, 0, 0, 0, e);
        check_frame(16, e, nb, "R7", pos);

        // R10 break idle and mid-frame
        cmd_break = 1'b1;
        ones = 0;
        for (int i = 0; i < 5; i++) begin
            cyc(1'b1);
            ones += txd;
        end
        chk(ones == 0, "R10", "break idle ones", ones, 0);
        cmd_break = 1'b0; #1;
        chk(txd == 1'b1, "R12", "mark after break", txd, 1);
        wr(8'hFF);
        run_ticks(20);
        cmd_break = 1'b1;
        ones = 0;
        for (int i = 0; i < 8; i++) begin
            cyc(1'b1);
            ones += txd;
        end
        chk(ones == 0, "R10", "break mid-frame ones", ones, 0);

        // R11 synchronous, two sync characters, data waiting before enable
        do_reset();
        cfg_sync = 1'b1; cfg_len = 2'b11; cfg_par_en = 1'b0; cfg_two_sync = 1'b1;
        sync_a = 8'h3C; sync_b = 8'hA5;
        wr(8'h5B);
        sq.delete();
        run_ticks(6);
        ones = 0;
        foreach (sq[i]) ones += sq[i];
        chk(ones == 6, "R3", "sync idle while disabled", ones, 6);
        sq.delete();
        cmd_txen = 1'b1;
        cyc(1'b0);
        chk(txempty == 1'b0, "R11", "empty with data loaded", txempty, 0);
        run_ticks(10);
        chk(txempty == 1'b1, "R11", "empty during sync fill", txempty, 1);
        run_ticks(30);
        begin
            logic [7:0] seq5 [5];
            int bad;
            seq5[0] = 8'h5B; seq5[1] = 8'h3C; seq5[2] = 8'hA5;
            seq5[3] = 8'h3C; seq5[4] = 8'hA5;
            bad = 0;
            for (int c = 0; c < 5; c++)
                for (int k = 0; k < 8; k++)
                    if (sq[c*8+k] != seq5[c][k]) bad++;
            chk(bad == 0, "R11", "two-sync stream mismatches", bad, 0);
        end

        // R11 R5 single sync, 5 bits, odd parity
        do_reset();
        cfg_sync = 1'b1; cfg_len = 2'b00; cfg_par_en = 1'b1; cfg_par_odd = 1'b1;
        cfg_two_sync = 1'b0; sync_a = 8'h0D;
        sq.delete();
        cmd_txen = 1'b1;
        cyc(1'b0);
        run_ticks(18);
        begin
            int bad;
            bit p;
            bad = 0;
            for (int c = 0; c < 3; c++) begin
                p = 1'b1;
                for (int k = 0; k < 5; k++) begin
                    if (sq[c*6+k] != sync_a[k]) bad++;
                    p ^= sync_a[k];
                end
                if (sq[c*6+5] != p) bad++;
            end
            chk(bad == 0, "R11", "single-sync parity stream mismatches", bad, 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule